// File: doc/BRIEF.md
# Start-triggered serial accumulator

The block adds up a stream of unsigned words whose length is given when the job is launched. A transition on the start input launches a job. In the same clock the element count is sampled. The words then follow on the data input, one per clock. When the last word has been added, the block raises a one-clock end flag, and the total is shown on the sum output. The total stays on the output until the next job is launched.

A parameter chooses which transition launches a job. With the default, a low-to-high transition of start launches it. The other setting uses a high-to-low transition. Because only a transition counts, start may stay at its active level for any number of clocks and still launch exactly one job. A finite state machine controls the block and has two states, idle and running. The running total is visible on the sum output while the job is in progress.

Top module: `sacc_top`

## Requirements
- R1: While rst_ni is low, and in the first clock after it is released, end_o is 0 and sum_o is 0.
- R2: With TRIG_FALLING = 0, a job starts at a clock edge where start_i is sampled 1 after being sampled 0 at the previous edge (start_i counts as 0 before the first edge after reset). count_i is sampled at that same edge. Holding start_i at 1 afterwards does not start a further job.
- R3: At the launch edge, sum_o is cleared to 0. data_i is then sampled at each of the next count_i edges, and each sample is added at once, so sum_o shows the running total.
- R4: end_o is 1 for exactly the one clock after the edge that samples the last data word. In that clock sum_o equals the total of the words, modulo 2^16.
- R5: A job launched with count_i = 0 raises end_o in the clock after the launch edge, and sum_o is 0.
- R6: A start transition sampled while a job is running is ignored. The running count, the total and the end timing are unchanged. A new job may be launched at the edge where end_o is 1.
- R7: After a job ends, sum_o holds its value until the next launch edge.
- R8: With TRIG_FALLING = 1, the behaviour is identical, except that the launch is an edge where start_i is sampled 0 after being sampled 1 at the previous edge.
- R9: The largest job, 255 words of value 255, gives sum_o = 65025 exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job launch; only its selected transition acts |
| count_i | input | 8 | Number of words, sampled at the launch edge |
| data_i | input | 8 | Data word, one per clock after the launch |
| end_o | output | 1 | One-clock pulse when the job is complete |
| sum_o | output | 16 | Running total; holds the final total between jobs |

## Verification
The hardest situations to reach from the ports are a start transition during a running job, and a new launch at the same edge where end_o is high. Both depend on exact cycle placement relative to the job length. The stimulus toggles start_i in the middle of the data phase. It also launches the next job at the first edge after the end pulse, and at the end-pulse edge itself. A bench model of the behaviour is compared against a rising-triggered instance and a falling-triggered instance every clock. Because both instances share the same inputs, each falling-edge job is seen by the rising instance as an unrelated zero-count or overlapping launch, and that case is also checked.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sacc_state_e;
endpackage

// File: rtl/sacc_edge.sv
module sacc_edge #(
  parameter bit TRIG_FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic trig_o
);
  logic start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_i;
  end

  generate
    if (TRIG_FALLING) begin : g_fall
      assign trig_o = start_q & ~start_i;
    end else begin : g_rise
      assign trig_o = start_i & ~start_q;
    end
  endgenerate
endmodule

// File: rtl/sacc_ctrl.sv
module sacc_ctrl
  import sacc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             clr_o,
  output logic             add_o,
  output logic             done_o,
  output logic [CNT_W-1:0] rem_o
);
  sacc_state_e      state_q;
  logic [CNT_W-1:0] rem_q;
  logic             done_q;
  logic             launch;

  assign launch = (state_q == ST_IDLE) && trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            if (count_i == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              rem_q   <= count_i;
            end
          end
        end
        ST_RUN: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign clr_o  = launch;
  assign add_o  = (state_q == ST_RUN);
  assign done_o = done_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/sacc_datapath.sv
module sacc_datapath #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= sum_q + SUM_W'(data_i);
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/sacc_top.sv
module sacc_top #(
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 8,
  parameter int SUM_W        = 16,
  parameter bit TRIG_FALLING = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              end_o,
  output logic [SUM_W-1:0]  sum_o
);
  logic             trig;
  logic             busy;
  logic             clr;
  logic             add;
  logic [CNT_W-1:0] rem;

  sacc_edge #(.TRIG_FALLING(TRIG_FALLING)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .trig_o (trig)
  );

  sacc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .count_i(count_i),
    .busy_o (busy),
    .clr_o  (clr),
    .add_o  (add),
    .done_o (end_o),
    .rem_o  (rem)
  );

  sacc_datapath #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_dp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .add_i (add),
    .data_i(data_i),
    .sum_o (sum_o)
  );
endmodule

// File: rtl/sacc_chk.sv
module sacc_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int SUM_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_i,
  input logic              busy_i,
  input logic [CNT_W-1:0]  rem_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [DATA_W-1:0] data_i,
  input logic              end_i,
  input logic [SUM_W-1:0]  sum_i
);
  // R5
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && trig_i && count_i == '0) |=> (end_i && sum_i == '0));

  // R6
  run_ignores_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rem_i > CNT_W'(1)) |=> (busy_i && rem_i == $past(rem_i) - 1'b1));

  // R7
  sum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !trig_i) |=> $stable(sum_i));

  // R3
  running_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (sum_i == $past(sum_i) + SUM_W'($past(data_i))));

  // R4
  end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |-> !busy_i);

  // R4
  end_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |-> $past(busy_i || trig_i));

  // R2
  launch_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && trig_i && count_i != '0) |=> (busy_i && rem_i == $past(count_i)));
endmodule

bind sacc_top sacc_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .trig_i (trig),
  .busy_i (busy),
  .rem_i  (rem),
  .count_i(count_i),
  .data_i (data_i),
  .end_i  (end_o),
  .sum_i  (sum_o)
);

// File: tb/tb_sacc_top.sv
`timescale 1ns/1ps
module tb_sacc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] count = 8'd0;
  logic [7:0] data = 8'd0;
  logic       end_r, end_f;
  logic [15:0] sum_r, sum_f;

  always #4 clk = ~clk;

  sacc_top #(.TRIG_FALLING(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .count_i(count),
    .data_i(data), .end_o(end_r), .sum_o(sum_r));

  sacc_top #(.TRIG_FALLING(1'b1)) dut_f (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .count_i(count),
    .data_i(data), .end_o(end_f), .sum_o(sum_f));

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural model, index 0 rising, 1 falling
  bit m_busy [2];
  int m_rem  [2];
  int m_sum  [2];
  bit m_end  [2];
  bit m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_busy[i] = 0; m_rem[i] = 0; m_sum[i] = 0; m_end[i] = 0;
      end
      m_prev = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit edge_seen;
        bit e;
        edge_seen = (i == 0) ? (start && !m_prev) : (!start && m_prev);
        e = 0;
        if (m_busy[i]) begin
          m_sum[i] = (m_sum[i] + data) % 65536;
          m_rem[i] = m_rem[i] - 1;
          if (m_rem[i] == 0) begin
            m_busy[i] = 0;
            e = 1;
          end
        end else if (edge_seen) begin
          m_sum[i] = 0;
          if (count == 0) e = 1;
          else begin
            m_busy[i] = 1;
            m_rem[i] = count;
          end
        end
        m_end[i] = e;
      end
      m_prev = start;
    end
  end

  task automatic check_one(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check_one(cur_req, "rise end_o", end_r, m_end[0]);
    check_one(cur_req, "rise sum_o", sum_r, m_sum[0]);
    check_one({"R8 ", cur_req}, "fall end_o", end_f, m_end[1]);
    check_one({"R8 ", cur_req}, "fall sum_o", sum_f, m_sum[1]);
  endtask

  task automatic cyc(input bit s, input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    compare();
    start = s; count = c; data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'd0, 8'($urandom));
  endtask

  // rising job: start high for hold cycles, count on the first
  task automatic rise_job(input int n, input int hold, input bit maxdata);
    cyc(1, 8'(n), 8'($urandom));
    for (int i = 0; i < n; i++)
      cyc((i < hold - 1) ? 1'b1 : 1'b0, 8'($urandom), maxdata ? 8'hFF : 8'($urandom));
  endtask

  // falling job: count presented as start drops
  task automatic fall_job(input int n);
    cyc(1, 8'($urandom), 8'($urandom));
    cyc(0, 8'(n), 8'($urandom));
    for (int i = 0; i < n; i++) cyc(0, 8'($urandom), 8'($urandom));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      fails++;
      $display("FAIL R4 watchdog actual=%0d cycles expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) begin
      @(negedge clk);
      check_one("R1", "rise end_o", end_r, 0);
      check_one("R1", "rise sum_o", sum_r, 0);
      check_one("R1", "fall end_o", end_f, 0);
      check_one("R1", "fall sum_o", sum_f, 0);
    end
    rst_n = 1'b1;
    idle(2);

    cur_req = "R3";
    rise_job(1, 1, 0);
    idle(3);
    rise_job(5, 1, 0);
    idle(2);

    cur_req = "R2";
    rise_job(6, 4, 0);
    idle(2);
    rise_job(3, 9, 0);
    idle(2);

    cur_req = "R5";
    rise_job(0, 1, 0);
    idle(2);
    rise_job(0, 1, 0);
    cyc(0, 8'd0, 8'd0);
    rise_job(0, 1, 0);
    idle(3);

    cur_req = "R6";
    cyc(1, 8'd8, 8'd1);
    cyc(0, 8'd0, 8'd10);
    cyc(1, 8'd2, 8'd20);
    cyc(0, 8'd0, 8'd30);
    cyc(1, 8'd0, 8'd40);
    cyc(1, 8'd0, 8'd50);
    cyc(0, 8'd3, 8'd60);
    cyc(1, 8'd1, 8'd70);
    cyc(0, 8'd0, 8'd80);
    cyc(1, 8'd2, 8'd5);   // launch at the end-pulse edge
    cyc(0, 8'd0, 8'd6);
    cyc(0, 8'd0, 8'd7);
    cyc(0, 8'd0, 8'd0);
    // back-to-back: next launch right after end
    rise_job(4, 1, 0);
    rise_job(2, 1, 0);
    idle(2);

    cur_req = "R7";
    rise_job(7, 1, 0);
    idle(20);

    cur_req = "R8";
    fall_job(4);
    idle(3);
    fall_job(0);
    idle(2);
    fall_job(10);
    idle(4);

    cur_req = "R9";
    rise_job(255, 1, 1);
    idle(3);
    fall_job(255);
    idle(3);

    cur_req = "R4";
    for (int k = 0; k < 30; k++) begin
      if (k % 2 == 0) rise_job($urandom_range(0, 20), $urandom_range(1, 5), 0);
      else fall_job($urandom_range(0, 20));
      idle($urandom_range(0, 3));
    end
    idle(5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule